// File: doc/BRIEF.md
# Zero-Cross Synchronized Update Controller

This block decides when a freshly received 44-bit control word becomes the active word that steers the analog switching paths of an audio processor. A word arrives with a one-cycle strobe at the end of each serial transfer. A two-bit apply-mode field inside the word either makes the whole word active at once or holds it pending until a zero-crossing is reported by one of four signal stages. Applying the word at a zero-crossing keeps switching clicks out of the audio.

In deferred mode, a two-bit tap field in the same word picks the stage whose zero-crossing pulse releases the pending word. Both the tap field and the mode field take effect as soon as the strobe arrives, so a single transfer can choose its own release point. A silent or very low-frequency signal may never cross zero. For that case a cycle-count timeout releases the pending word anyway. A later word that arrives while one is still pending replaces it.

An active-low mute input passes through a synchronizer and then forces the fader attenuation field of the output word to full attenuation. The latched data underneath is left unchanged. Bits that are reserved for factory test always read as zero at the output.

Top module: `zcu_apply_ctrl`

## Requirements
- R1: After reset, `act_word` is all zeros and `busy` is low.
- R2: When a strobe carries apply-mode field `wr_word[37:36]` equal to 01, 10 or 11, the whole word appears on `act_word` in the cycle after the strobe edge and `busy` is low. A word that was still pending is discarded.
- R3: When a strobe carries apply-mode 00, `act_word[39:36]` takes the new mode and tap bits in the cycle after the strobe edge. All other output bits keep their previous values and `busy` goes high.
- R4: The tap index is `wr_word[39:38]` (bit 38 is the low bit): 0 input selector, 1 volume, 2 tone, 3 fader. While `busy` is high, a pulse on `zc_pulse[index]` makes the pending word active at the next edge and drops `busy`. Pulses on the other three inputs are ignored.
- R5: If no selected pulse arrives, the pending word becomes active exactly `TIMEOUT_CYC` clock edges after the strobe edge, and `busy` falls at the same time.
- R6: A deferred-mode strobe while `busy` is high replaces the pending word and restarts the timeout from that strobe. A strobe takes priority over a zero-cross pulse in the same cycle.
- R7: While `mute_n` is low, `act_word[31:28]` reads 4'b1111 from the second clock edge after the change onward. After release, the latched value returns on the second edge. No other bit is affected.
- R8: `act_word[3]`, `act_word[42]` and `act_word[43]` are always zero, whatever was written.
- R9: Zero-cross pulses while `busy` is low have no effect on `act_word` or `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle strobe: a complete word is on `wr_word` |
| wr_word | input | 44 | Received control word |
| zc_pulse | input | 4 | Zero-crossing pulses, index 0 selector, 1 volume, 2 tone, 3 fader |
| mute_n | input | 1 | External mute, active low, asynchronous |
| act_word | output | 44 | Active control word, with mute overlay applied |
| busy | output | 1 | High while a word is pending |

## Verification
Faults in this block show up as timing errors on `act_word` and `busy`, not as wrong data bits. A wrongly decoded tap leaves `busy` high after the intended pulse, and the word then appears only at the timeout, up to `TIMEOUT_CYC` cycles late. A timer that is off by one, or that does not restart, moves the release edge by one or more cycles, so the bench samples the cycle just before the expected release as well as the release cycle itself. A mute synchronizer with the wrong depth or the wrong reset value shows in the fader field one edge early or late, or directly after reset.

// File: rtl/zcu_pkg.sv
`timescale 1ns/1ps
package zcu_pkg;

    localparam int CW_W    = 44;
    localparam int NTAP    = 4;
    localparam int MODE_LO = 36;
    localparam int TAP_LO  = 38;
    localparam int CTRL_W  = 4;   // mode and tap bits together
    localparam int FADE_LO = 28;
    localparam int FADE_W  = 4;
    localparam int RSV_BIT = 3;
    localparam int TEST_LO = 42;

    typedef logic [CW_W-1:0] cword_t;

    typedef enum logic [1:0] {
        APPLY_ON_ZC = 2'b00,
        APPLY_NOW_A = 2'b01,
        APPLY_NOW_B = 2'b10,
        APPLY_NOW   = 2'b11
    } apply_mode_e;

    typedef enum logic [1:0] {
        TAP_INPUT  = 2'd0,
        TAP_VOLUME = 2'd1,
        TAP_TONE   = 2'd2,
        TAP_FADER  = 2'd3
    } zc_tap_e;

    typedef struct packed {
        logic    valid;
        logic    immediate;
        zc_tap_e tap;
        cword_t  word;
    } wr_req_t;

    function automatic apply_mode_e mode_of(cword_t w);
        return apply_mode_e'(w[MODE_LO +: 2]);
    endfunction

    function automatic zc_tap_e tap_of(cword_t w);
        return zc_tap_e'(w[TAP_LO +: 2]);
    endfunction

    // Reserved and test bits never reach the switching paths.
    function automatic cword_t scrub(cword_t w);
        cword_t r = w;
        r[RSV_BIT]      = 1'b0;
        r[TEST_LO +: 2] = 2'b00;
        return r;
    endfunction

    // Mode and tap bits of a new word replace those of the active word.
    function automatic cword_t ctrl_merge(cword_t act, cword_t nw);
        cword_t r = act;
        r[MODE_LO +: CTRL_W] = nw[MODE_LO +: CTRL_W];
        return r;
    endfunction

    function automatic cword_t mute_overlay(cword_t w, logic muted);
        cword_t r = w;
        if (muted) r[FADE_LO +: FADE_W] = '1;
        return r;
    endfunction

endpackage

// File: rtl/zcu_req_decode.sv
`timescale 1ns/1ps
module zcu_req_decode
    import zcu_pkg::*;
(
    input  logic    wr_stb,
    input  cword_t  wr_word,
    output wr_req_t req
);

    always_comb begin
        req.valid     = wr_stb;
        req.immediate = (mode_of(wr_word) != APPLY_ON_ZC);
        req.tap       = tap_of(wr_word);
        req.word      = scrub(wr_word);
    end

endmodule

// File: rtl/zcu_mute_sync.sv
`timescale 1ns/1ps
module zcu_mute_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mute_n,
    output logic mute_on
);

    logic [STAGES-1:0] sq;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sq <= 1'b1;
                else     sq <= mute_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sq <= '1;
                else     sq <= {sq[STAGES-2:0], mute_n};
            end
        end
    endgenerate

    assign mute_on = ~sq[STAGES-1];

endmodule

// File: rtl/zcu_zc_timer.sv
`timescale 1ns/1ps
module zcu_zc_timer
    import zcu_pkg::*;
#(
    parameter int TIMEOUT_CYC = 4_000_000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic            armed,
    input  zc_tap_e         tap,
    input  logic [NTAP-1:0] zc_pulse,
    output logic            fire
);

    localparam int CNT_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [NTAP-1:0]  hit;
    logic             expire;

    generate
        for (genvar g = 0; g < NTAP; g++) begin : g_tap
            assign hit[g] = zc_pulse[g] && (tap == zc_tap_e'(g));
        end
    endgenerate

    assign expire = armed && (cnt_q == LAST);
    assign fire   = !restart && (expire || (armed && |hit));

    always_ff @(posedge clk) begin
        if (rst || restart)        cnt_q <= '0;
        else if (armed && !expire) cnt_q <= cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/zcu_word_regs.sv
`timescale 1ns/1ps
module zcu_word_regs
    import zcu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    input  logic    fire,
    output cword_t  act_q,
    output cword_t  pend_q,
    output logic    busy_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            pend_q <= '0;
            busy_q <= 1'b0;
        end else if (req.valid) begin
            if (req.immediate) begin
                act_q  <= req.word;
                busy_q <= 1'b0;
            end else begin
                pend_q <= req.word;
                act_q  <= ctrl_merge(act_q, req.word);
                busy_q <= 1'b1;
            end
        end else if (fire) begin
            act_q  <= pend_q;
            busy_q <= 1'b0;
        end
    end

endmodule

// File: rtl/zcu_apply_ctrl.sv
`timescale 1ns/1ps
module zcu_apply_ctrl
    import zcu_pkg::*;
#(
    parameter int TIMEOUT_CYC = 4_000_000,
    parameter int MUTE_SYNC   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_stb,
    input  logic [43:0] wr_word,
    input  logic [3:0]  zc_pulse,
    input  logic        mute_n,
    output logic [43:0] act_word,
    output logic        busy
);

    wr_req_t req;
    cword_t  act_q;
    cword_t  pend_q;
    logic    busy_q;
    logic    fire;
    logic    mute_on;

    zcu_req_decode u_dec (
        .wr_stb  (wr_stb),
        .wr_word (wr_word),
        .req     (req)
    );

    zcu_zc_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .restart  (req.valid),
        .armed    (busy_q),
        .tap      (tap_of(pend_q)),
        .zc_pulse (zc_pulse),
        .fire     (fire)
    );

    zcu_word_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .fire   (fire),
        .act_q  (act_q),
        .pend_q (pend_q),
        .busy_q (busy_q)
    );

    zcu_mute_sync #(.STAGES(MUTE_SYNC)) u_mute (
        .clk     (clk),
        .rst     (rst),
        .mute_n  (mute_n),
        .mute_on (mute_on)
    );

    assign act_word = mute_overlay(act_q, mute_on);
    assign busy     = busy_q;

endmodule

// File: rtl/zcu_apply_ctrl_chk.sv
`timescale 1ns/1ps
module zcu_apply_ctrl_chk #(
    parameter int TIMEOUT_CYC = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_stb,
    input logic [3:0]  wr_ctl,
    input logic [3:0]  zc_pulse,
    input logic        mute_n,
    input logic [43:0] act_word,
    input logic        busy
);

    localparam int WC_W = $clog2(TIMEOUT_CYC + 1) + 1;
    localparam logic [WC_W-1:0] WC_MAX = '1;

    logic [WC_W-1:0] wait_cnt;
    logic [1:0]      age;

    always_ff @(posedge clk) begin
        if (rst)                              wait_cnt <= '0;
        else if (wr_stb)                      wait_cnt <= '0;
        else if (busy && wait_cnt != WC_MAX)  wait_cnt <= wait_cnt + WC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (act_word == '0 && !busy)); // R1

    AST_IMMEDIATE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_ctl[1:0] != 2'b00) |=> !busy); // R2

    AST_DEFER_BUSY: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_ctl[1:0] == 2'b00) |=> busy); // R3

    AST_CTRL_AT_ONCE: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (act_word[39:36] == $past(wr_ctl))); // R3

    AST_TAP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_stb && zc_pulse[act_word[39:38]]) |=> !busy); // R4

    AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (wait_cnt < WC_W'(TIMEOUT_CYC))); // R5

    AST_MUTE_FORCE: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && !$past(mute_n) && !$past(mute_n, 2)) |-> (act_word[31:28] == 4'hF)); // R7

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (act_word[3] == 1'b0 && act_word[43:42] == 2'b00)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !wr_stb) |=> $stable({act_word[43:32], act_word[27:0]})); // R9

endmodule

bind zcu_apply_ctrl zcu_apply_ctrl_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_stb   (wr_stb),
    .wr_ctl   (wr_word[39:36]),
    .zc_pulse (zc_pulse),
    .mute_n   (mute_n),
    .act_word (act_word),
    .busy     (busy)
);

// File: tb/zcu_apply_ctrl_tb_top.sv
`timescale 1ns/1ps
module zcu_apply_ctrl_tb_top;

    localparam int TMO = 50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [43:0] wr_word = '0;
    logic [3:0]  zc_pulse = '0;
    logic        mute_n = 1'b1;
    logic [43:0] act_word;
    logic        busy;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [43:0] model = '0;

    always #2.5 clk = ~clk;

    zcu_apply_ctrl #(.TIMEOUT_CYC(TMO), .MUTE_SYNC(2)) dut_i (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_word(wr_word),
        .zc_pulse(zc_pulse), .mute_n(mute_n), .act_word(act_word), .busy(busy)
    );

    function automatic logic [43:0] clean(logic [43:0] w);
        logic [43:0] r = w;
        r[3] = 1'b0;
        r[43:42] = 2'b00;
        return r;
    endfunction

    function automatic logic [43:0] mk(logic [43:0] base, logic [1:0] mode, logic [1:0] tap);
        logic [43:0] r = base;
        r[37:36] = mode;
        r[39:38] = tap;
        return r;
    endfunction

    function automatic logic [43:0] with_ctrl(logic [43:0] act, logic [43:0] nw);
        logic [43:0] r = act;
        r[39:36] = nw[39:36];
        return r;
    endfunction

    task automatic cmp(input string tag, input logic [43:0] got, input logic [43:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic send(input logic [43:0] w, input logic [3:0] zc);
        wr_word  = w;
        wr_stb   = 1'b1;
        zc_pulse = zc;
        @(negedge clk);
        wr_stb   = 1'b0;
        zc_pulse = '0;
    endtask

    task automatic pulse(input logic [3:0] v);
        zc_pulse = v;
        @(negedge clk);
        zc_pulse = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        cmp("R1 act_word after reset", act_word, '0);
        cmp("R1 busy after reset", {43'd0, busy}, 44'd0);
    endtask

    task automatic t_immediate;
        for (int m = 1; m < 4; m++) begin
            logic [43:0] w = mk(44'hC0F_1234_5678 ^ (44'(m) << 20) | 44'h8, 2'(m), 2'(m));
            send(w, 4'h0);
            model = clean(w);
            cmp("R2 immediate word", act_word, model);
            cmp("R2 immediate busy", {43'd0, busy}, 44'd0);
            cmp("R8 reserved bits", {41'd0, act_word[43:42], act_word[3]}, 44'd0);
        end
    endtask

    task automatic t_zc_taps;
        for (int t = 0; t < 4; t++) begin
            logic [43:0] w = mk(44'hFFF_A5A5_0F0F ^ (44'(t) * 44'h111_1111), 2'b00, 2'(t));
            logic [3:0]  wrong = 4'b0001 << ((t + 1) % 4);
            logic [3:0]  right = 4'b0001 << t;
            send(w, 4'h0);
            model = with_ctrl(model, w);
            cmp("R3 deferred busy", {43'd0, busy}, 44'd1);
            cmp("R3 only ctrl bits move", act_word, model);
            pulse(wrong);
            cmp("R4 other tap ignored busy", {43'd0, busy}, 44'd1);
            cmp("R4 other tap ignored word", act_word, model);
            pulse(right);
            model = clean(w);
            cmp("R4 selected tap releases", act_word, model);
            cmp("R4 busy drops on release", {43'd0, busy}, 44'd0);
            cmp("R8 reserved after release", {41'd0, act_word[43:42], act_word[3]}, 44'd0);
        end
    endtask

    task automatic t_timeout;
        logic [43:0] w = mk(44'h123_4567_89AB, 2'b00, 2'd0);
        send(w, 4'h0);
        model = with_ctrl(model, w);
        idle(TMO - 1);
        cmp("R5 still pending before timeout", {43'd0, busy}, 44'd1);
        cmp("R5 word held before timeout", act_word, model);
        idle(1);
        model = clean(w);
        cmp("R5 released at timeout", act_word, model);
        cmp("R5 busy low at timeout", {43'd0, busy}, 44'd0);
    endtask

    task automatic t_replace;
        logic [43:0] a = mk(44'h0AA_0000_1111, 2'b00, 2'd3);
        logic [43:0] b = mk(44'h055_2222_3333, 2'b00, 2'd1);
        logic [43:0] c = mk(44'h011_4444_5555, 2'b00, 2'd2);
        logic [43:0] d = mk(44'h022_6666_7777, 2'b00, 2'd2);
        logic [43:0] e = mk(44'h033_8888_9999, 2'b00, 2'd0);
        logic [43:0] f = mk(44'h044_AAAA_BBBB, 2'b11, 2'd0);
        send(a, 4'h0);
        model = with_ctrl(model, a);
        idle(20);
        send(b, 4'h0);
        model = with_ctrl(model, b);
        cmp("R6 replacement ctrl bits", act_word, model);
        pulse(4'b1000);
        cmp("R6 old tap no longer armed", {43'd0, busy}, 44'd1);
        idle(TMO - 2);
        cmp("R6 timer restarted by new word", {43'd0, busy}, 44'd1);
        cmp("R6 word held after restart", act_word, model);
        idle(1);
        model = clean(b);
        cmp("R6 replacement word released", act_word, model);
        send(c, 4'h0);
        model = with_ctrl(model, c);
        send(d, 4'b0100);
        model = with_ctrl(model, d);
        cmp("R6 strobe beats same-cycle pulse busy", {43'd0, busy}, 44'd1);
        cmp("R6 strobe beats same-cycle pulse word", act_word, model);
        pulse(4'b0100);
        model = clean(d);
        cmp("R6 later word released", act_word, model);
        send(e, 4'h0);
        send(f, 4'h0);
        model = clean(f);
        cmp("R6 immediate word discards pending", act_word, model);
        cmp("R6 busy low after immediate", {43'd0, busy}, 44'd0);
        idle(TMO + 2);
        cmp("R6 discarded word never appears", act_word, model);
    endtask

    task automatic t_idle_pulse;
        pulse(4'hF);
        cmp("R9 idle pulses leave word", act_word, model);
        cmp("R9 idle pulses leave busy", {43'd0, busy}, 44'd0);
    endtask

    task automatic t_mute;
        logic [43:0] w = mk(44'h0CC_5000_0000, 2'b11, 2'd0);
        logic [43:0] g = mk(44'h0DD_3000_0ABC, 2'b11, 2'd1);
        send(w, 4'h0);
        model = clean(w);
        mute_n = 1'b0;
        idle(1);
        cmp("R7 mute not yet through synchronizer", act_word, model);
        idle(1);
        cmp("R7 fader forced while muted", act_word, model | (44'hF << 28));
        send(g, 4'h0);
        model = clean(g);
        cmp("R7 new word under mute", act_word, model | (44'hF << 28));
        mute_n = 1'b1;
        idle(1);
        cmp("R7 release not yet through synchronizer", act_word, model | (44'hF << 28));
        idle(1);
        cmp("R7 latched fader returns", act_word, model);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_immediate();
        t_zc_taps();
        t_timeout();
        t_replace();
        t_idle_pulse();
        t_mute();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog R1-all actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule